// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing engine of a 256-byte serial memory that answers as a slave on a two-wire (I2C-style) bus. A fast system clock oversamples the bus clock and data lines. Each line passes through a short synchronizer and a majority filter. The engine then finds START and STOP conditions and reads the bus bits in. It pulls the data line low through an open-drain enable to acknowledge bytes and to send read data.

The first byte of every transfer selects a device. Its four top bits give a type, the next three bits must match the strapped chip-select inputs, and the lowest bit gives the direction. One type reaches the memory and a second type carries a protection command. The engine keeps a word-address counter, so it can serve current-address, random-address and sequential reads from a behavioural register file. It reports each received data byte to a page-write block, pulses a commit at STOP, and pulses a protection request at STOP for the protection block. While that write block reports a busy cycle, every select byte goes unanswered, so the host can poll until the cycle ends.

Top module: `tw_eeprom_slave`

## Requirements
- R1: A select byte is acknowledged only when its bits 7:4 are 1010 (memory access) or 0110 (protection command) and its bits 3:1 equal `chip_sel_i`. Any other byte leaves SDA released for the ninth clock, and the transfer is ignored until the next START.
- R2: A protection select (0110) in write direction (bit 0 = 0) acknowledges the following address and data bytes, writes nothing, and pulses `prot_cmd_o` at STOP. In read direction (bit 0 = 1) it is acknowledged and nothing more is driven.
- R3: The engine changes its SDA drive only while SCL is low.
- R4: A START at any point releases SDA and returns the engine to waiting for a select byte. A partly received byte is discarded and no commit follows.
- R5: Every accepted byte is acknowledged by holding SDA low through the ninth SCL clock.
- R6: A write-direction select, then a word-address byte, then a repeated START and a read select returns the byte at that address, MSB first.
- R7: A current-address read returns the byte at the last accessed address plus one.
- R8: In a sequential read, each master ACK advances to the next address, wrapping from 255 to 0. A master NACK ends the read and leaves SDA released.
- R9: While `busy_i` is high, every select byte is left unacknowledged.
- R10: Each data byte of a memory write is stored and strobed on `wr_stb_o` with its address and data. The address advances within its 16-byte page, so the low four bits wrap. A STOP after at least one data byte pulses `wr_commit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| chip_sel_i | input | 3 | Strapped chip-select value (unstrapped = 0) |
| busy_i | input | 1 | Internal write cycle in progress |
| sda_oe_o | output | 1 | Pull SDA low when high (open drain) |
| wr_stb_o | output | 1 | One-cycle strobe per received data byte |
| wr_addr_o | output | 8 | Address of the strobed data byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_commit_o | output | 1 | Pulse at STOP that ends a write with data |
| prot_cmd_o | output | 1 | Pulse at STOP that ends a protection command |

## Verification
Writes are tried as a page burst that crosses a page end, so a page roll can be told apart from a plain increment. Reads are tried in three forms: a random read started at address 255 and continued sequentially, which separates a full-width wrap from a missing one; a current-address read that follows it; and a read after a write aborted by START mid-byte, which shows whether a partial byte was stored. Select bytes with a wrong chip select, a wrong type, the protection type and a busy flag check that the acknowledge decision depends on each field. A line monitor counts every change of the SDA drive while SCL is high.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WADDR,
    PH_WDATA,
    PH_READ
  } tw_phase_e;

  localparam logic [3:0] TYPE_MEM  = 4'b1010;
  localparam logic [3:0] TYPE_PROT = 4'b0110;
  localparam int         BYTE_W    = 8;
endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int TAPS        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int CNT_W = $clog2(TAPS + 1);
  localparam int HALF  = TAPS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [TAPS-1:0]        hist_q;
  logic [CNT_W-1:0]       ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < TAPS; i++) ones = ones + CNT_W'(hist_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      q_o    <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], d_i};
      hist_q <= {hist_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
      q_o    <= (ones > CNT_W'(HALF));
    end
  end
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        chip_sel_i,
  input  logic              busy_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_commit_o,
  output logic              prot_cmd_o
);
  localparam int LINES = 2;

  // Next write address: low PAGE_W bits roll, upper bits hold.
  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] lo;
    lo = a[PAGE_W-1:0] + 1'b1;
    return {a[ADDR_W-1:PAGE_W], lo};
  endfunction

  function automatic logic sel_hit(input logic [7:0] sel, input logic [2:0] cs);
    return ((sel[7:4] == TYPE_MEM) || (sel[7:4] == TYPE_PROT)) && (sel[3:1] == cs);
  endfunction

  // Line conditioning
  logic [LINES-1:0] raw_lines, filt_lines;
  assign raw_lines = {sda_i, scl_i};
  for (genvar g = 0; g < LINES; g++) begin : g_line
    tw_line_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) u_filt (
      .clk(clk), .rst_n(rst_n), .d_i(raw_lines[g]), .q_o(filt_lines[g])
    );
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  // Named bus events
  logic start_ev, stop_ev, scl_rise, scl_fall;
  assign start_ev = scl_q & scl_f & sda_q & ~sda_f;
  assign stop_ev  = scl_q & scl_f & ~sda_q & sda_f;
  assign scl_rise = ~scl_q & scl_f;
  assign scl_fall = scl_q & ~scl_f;

  // Engine state
  tw_phase_e         phase, next_ph;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg, txreg;
  logic [ADDR_W-1:0] addr_ctr;
  logic              prot_sel, prot_armed, wrote_any;
  logic [BYTE_W-1:0] rd_data;
  logic [2:0]        tx_idx;
  logic              dev_eval, dev_hit, in_dev, in_read, byte_done;

  assign tx_idx    = 3'(4'd7 - bitcnt);
  assign byte_done = scl_fall && (bitcnt == 4'd8);
  assign dev_eval  = byte_done && (phase == PH_DEV);
  assign dev_hit   = sel_hit(shreg, chip_sel_i) && !busy_i;
  assign in_dev    = (phase == PH_DEV);
  assign in_read   = (phase == PH_READ);

  tw_regfile #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(wr_stb_o), .waddr(wr_addr_o), .wdata(wr_data_o),
    .raddr(addr_ctr), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      next_ph     <= PH_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      txreg       <= '0;
      addr_ctr    <= '0;
      prot_sel    <= 1'b0;
      prot_armed  <= 1'b0;
      wrote_any   <= 1'b0;
      sda_oe_o    <= 1'b0;
      wr_stb_o    <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
      prot_cmd_o  <= 1'b0;
    end else begin
      wr_stb_o    <= 1'b0;
      wr_commit_o <= 1'b0;
      prot_cmd_o  <= 1'b0;
      if (start_ev) begin
        phase      <= PH_DEV;
        bitcnt     <= '0;
        sda_oe_o   <= 1'b0;
        wrote_any  <= 1'b0;
        prot_armed <= 1'b0;
      end else if (stop_ev) begin
        phase       <= PH_IDLE;
        sda_oe_o    <= 1'b0;
        wr_commit_o <= wrote_any;
        prot_cmd_o  <= prot_armed;
        wrote_any   <= 1'b0;
        prot_armed  <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_f};
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
            if (phase == PH_READ) next_ph <= sda_f ? PH_IDLE : PH_READ;
          end
        end
        if (byte_done) begin
          case (phase)
            PH_DEV: begin
              sda_oe_o <= dev_hit;
              prot_sel <= (shreg[7:4] == TYPE_PROT);
              if (!dev_hit)                       next_ph <= PH_IDLE;
              else if (!shreg[0])                 next_ph <= PH_WADDR;
              else if (shreg[7:4] == TYPE_PROT)   next_ph <= PH_IDLE;
              else                                next_ph <= PH_READ;
            end
            PH_WADDR: begin
              sda_oe_o <= 1'b1;
              if (!prot_sel) addr_ctr <= shreg[ADDR_W-1:0];
              next_ph <= PH_WDATA;
            end
            PH_WDATA: begin
              sda_oe_o <= 1'b1;
              next_ph  <= PH_WDATA;
              if (prot_sel) begin
                prot_armed <= 1'b1;
              end else begin
                wr_stb_o  <= 1'b1;
                wr_addr_o <= addr_ctr;
                wr_data_o <= shreg;
                addr_ctr  <= page_next(addr_ctr);
                wrote_any <= 1'b1;
              end
            end
            default: sda_oe_o <= 1'b0;
          endcase
        end else if (scl_fall && bitcnt == 4'd9) begin
          bitcnt <= '0;
          phase  <= next_ph;
          if (next_ph == PH_READ) begin
            txreg    <= rd_data;
            sda_oe_o <= ~rd_data[7];
            addr_ctr <= addr_ctr + 1'b1;
          end else begin
            sda_oe_o <= 1'b0;
          end
        end else if (scl_fall && phase == PH_READ && bitcnt != 4'd0) begin
          sda_oe_o <= ~txreg[tx_idx];
        end
      end
    end
  end
endmodule

// File: rtl/tw_eeprom_checker.sv
module tw_eeprom_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       scl_q,
  input logic       sda_oe,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       dev_eval,
  input logic       busy_i,
  input logic       in_dev,
  input logic       in_read,
  input logic [3:0] bitcnt
);
  assert_drive_quiet_scl_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && scl_f) |-> $stable(sda_oe));

  assert_start_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (!sda_oe && in_dev && bitcnt == 4'd0));

  assert_stop_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  assert_ack_at_ninth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && !in_read) |-> (bitcnt == 4'd8));

  assert_busy_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_eval && busy_i) |=> !sda_oe);
endmodule

bind tw_eeprom_slave tw_eeprom_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .scl_q(scl_q), .sda_oe(sda_oe_o),
  .start_ev(start_ev), .stop_ev(stop_ev), .dev_eval(dev_eval), .busy_i(busy_i),
  .in_dev(in_dev), .in_read(in_read), .bitcnt(bitcnt)
);

// File: tb/tb_tw_eeprom_slave.sv
module tb_tw_eeprom_slave;
  localparam int Q  = 20;
  localparam int WD = 150000;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic [2:0] cs = 3'd5;
  logic       sda_oe, wr_stb, wr_commit, prot_cmd;
  logic [7:0] wr_addr, wr_data;
  wire        sda_line = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  tw_eeprom_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .chip_sel_i(cs),
    .busy_i(busy), .sda_oe_o(sda_oe), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_commit_o(wr_commit), .prot_cmd_o(prot_cmd)
  );

  int n_chk = 0, n_bad = 0, wr_cnt = 0, commit_cnt = 0, prot_cnt = 0, r3_viol = 0;
  logic [7:0] log_a [16];
  logic [7:0] log_d [16];
  logic oe_prev = 1'b0, scl_prev = 1'b1;
  bit done = 0;

  always @(posedge clk) begin
    if (wr_stb) begin
      log_a[wr_cnt % 16] <= wr_addr;
      log_d[wr_cnt % 16] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (wr_commit) commit_cnt <= commit_cnt + 1;
    if (prot_cmd)  prot_cnt   <= prot_cnt + 1;
    if (rst_n && sda_oe !== oe_prev && scl && scl_prev) r3_viol <= r3_viol + 1;
    oe_prev  <= sda_oe;
    scl_prev <= scl;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wq(); m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    wq(); m_sda = b; wq(); scl = 1'b1; wq(2); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    wq(); m_sda = 1'b1; wq(); scl = 1'b1; wq(); acked = !sda_line; wq(); scl = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      wq(2); scl = 1'b1; wq(); d[i] = sda_line; wq(); scl = 1'b0;
    end
    wq(); m_sda = !mack; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq(); m_sda = 1'b1;
  endtask

  function automatic logic [7:0] sel(input logic [3:0] t, input logic [2:0] c, input logic rw);
    return {t, c, rw};
  endfunction

  task automatic wr_one(input logic [7:0] a, input logic [7:0] d);
    logic k;
    bus_start();
    send_byte(sel(4'hA, cs, 1'b0), k);
    send_byte(a, k);
    send_byte(d, k);
    bus_stop();
  endtask

  task automatic t_reset();
    check("reset R5 sda released", sda_oe, 1'b0);
    check("reset R10 no strobe", wr_cnt, 0);
  endtask

  task automatic t_page_write();
    logic k;
    bus_start();
    send_byte(sel(4'hA, cs, 1'b0), k); check("R1 memory select ack", k, 1'b1);
    send_byte(8'h1E, k);               check("R5 word address ack", k, 1'b1);
    send_byte(8'hA1, k);               check("R5 data ack", k, 1'b1);
    send_byte(8'hB2, k);
    send_byte(8'hC3, k);
    bus_stop();
    check("R10 strobe count", wr_cnt, 3);
    check("R10 addr0", log_a[0], 8'h1E);
    check("R10 addr1", log_a[1], 8'h1F);
    check("R10 page roll addr", log_a[2], 8'h10);
    check("R10 data2", log_d[2], 8'hC3);
    check("R10 commit pulse", commit_cnt, 1);
  endtask

  task automatic t_reads();
    logic k;
    logic [7:0] d;
    wr_one(8'hFF, 8'h5A);
    wr_one(8'h00, 8'h3C);
    wr_one(8'h01, 8'h77);
    wr_one(8'h02, 8'hE4);
    bus_start();
    send_byte(sel(4'hA, cs, 1'b0), k);
    send_byte(8'hFF, k);
    bus_start();
    send_byte(sel(4'hA, cs, 1'b1), k); check("R6 read select ack", k, 1'b1);
    recv_byte(1'b1, d);                check("R6 random read data", d, 8'h5A);
    recv_byte(1'b1, d);                check("R8 wrap 255 to 0", d, 8'h3C);
    recv_byte(1'b0, d);                check("R8 sequential next", d, 8'h77);
    wq();                              check("R8 released after nack", sda_line, 1'b1);
    bus_stop();
    bus_start();
    send_byte(sel(4'hA, cs, 1'b1), k);
    recv_byte(1'b0, d);                check("R7 current address read", d, 8'hE4);
    bus_stop();
    check("R6 reads cause no strobe", wr_cnt, 7);
  endtask

  task automatic t_mismatch();
    logic k;
    bus_start();
    send_byte(sel(4'hA, 3'd4, 1'b0), k); check("R1 wrong chip select nack", k, 1'b0);
    send_byte(8'h30, k);                 check("R1 ignored after nack", k, 1'b0);
    bus_stop();
    bus_start();
    send_byte(sel(4'hB, cs, 1'b0), k);   check("R1 wrong type nack", k, 1'b0);
    bus_stop();
    check("R1 no write from ignored bytes", wr_cnt, 7);
  endtask

  task automatic t_busy();
    logic k;
    logic [7:0] d;
    busy = 1'b1;
    bus_start();
    send_byte(sel(4'hA, cs, 1'b1), k); check("R9 busy nack", k, 1'b0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(sel(4'hA, cs, 1'b1), k); check("R9 ack after busy clears", k, 1'b1);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic t_protect();
    logic k;
    int c0;
    c0 = commit_cnt;
    bus_start();
    send_byte(sel(4'h6, cs, 1'b0), k); check("R2 protect select ack", k, 1'b1);
    send_byte(8'h00, k);               check("R2 dummy address ack", k, 1'b1);
    send_byte(8'h00, k);               check("R2 dummy data ack", k, 1'b1);
    bus_stop();
    check("R2 protect pulse", prot_cnt, 1);
    check("R2 no memory strobe", wr_cnt, 7);
    check("R2 no commit", commit_cnt, c0);
    bus_start();
    send_byte(sel(4'h6, cs, 1'b1), k); check("R2 protect status ack", k, 1'b1);
    wq();                              check("R2 status read drives nothing", sda_line, 1'b1);
    bus_stop();
  endtask

  task automatic t_abort();
    logic k;
    logic [7:0] d;
    int c0, w0;
    wr_one(8'h40, 8'h99);
    c0 = commit_cnt;
    w0 = wr_cnt;
    bus_start();
    send_byte(sel(4'hA, cs, 1'b0), k);
    send_byte(8'h40, k);
    for (int i = 7; i >= 4; i--) send_bit(1'b0);
    bus_start();
    check("R4 start releases sda", sda_oe, 1'b0);
    send_byte(sel(4'hA, cs, 1'b1), k); check("R4 select after abort ack", k, 1'b1);
    recv_byte(1'b0, d);                check("R4 partial byte discarded", d, 8'h99);
    bus_stop();
    check("R4 no strobe from partial byte", wr_cnt, w0);
    check("R4 no commit after abort", commit_cnt, c0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_page_write();
    t_reads();
    t_mismatch();
    t_busy();
    t_protect();
    t_abort();
    check("R3 drive changes while SCL high", r3_viol, 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule